// File: doc/BRIEF.md
# Load/Store Access Fault Checker

This block sits beside the memory stage of a processor pipeline and inspects every data access together with the bus-error indications from both the instruction and data sides. In a single cycle it classifies the access as clean, misaligned or a stack-bound violation, and it classifies any bus error as an instruction-side or data-side unassigned-address fault. The result is written into an exception address register and an exception status word. A one-cycle exception request goes to the trap logic when the fault class's own enable rules allow it.

Each fault class is gated differently. A misalignment is always recorded, but it requests a trap only while exception-enable is set. A stack-bound violation always records and always requests. A bus error is invisible while exception-enable is clear. When exception-enable is set, a bus error records its address, and it writes its cause code and requests a trap only if the trap-configuration bit for its side is set. When several faults arrive together, one wins by a fixed priority.

The control is a two-state machine. In `ST_QUIET` the request output is low. In `ST_TRAP` it is high for exactly one cycle. The transition `GO_TRAP` (from either state to `ST_TRAP`) is taken on every cycle in which a fault that raises a request is recorded. The transition `GO_QUIET` (from either state to `ST_QUIET`) is taken on every other cycle.

Top module: `access_fault_chk`

## Requirements
- R1: After reset, exc_addr and exc_status are zero and exc_req is low.
- R2: An access with acc_valid high is misaligned when acc_addr ANDed with the size mask is nonzero. acc_size 2'b00 (byte) has mask 0, 2'b01 (halfword) has mask 1, and 2'b10 or 2'b11 (word) has mask 3.
- R3: On a recorded misalignment, exc_addr takes acc_addr. exc_status holds cause 1 in bits 4:0, acc_rd in bits 9:5, acc_write in bit 10, and a word-size flag in bit 11. All other status bits are zero.
- R4: A misalignment updates exc_addr and exc_status whatever the value of exc_enable, and it raises exc_req only when exc_enable is 1.
- R5: An access with acc_valid and acc_stack high whose address is below stk_lo or above stk_hi (unsigned, both bounds inclusive-legal) loads exc_addr with the address and exc_status with 7. It always raises exc_req.
- R6: While exc_enable is 0, bus_err has no effect: the registers and exc_req behave as if bus_err were low.
- R7: With exc_enable set, a bus error loads exc_addr with bus_addr. On the instruction side (bus_ifetch=1) with itrap_en=1, exc_status becomes 3 and exc_req rises. On the data side with dtrap_en=1, exc_status becomes 4 and exc_req rises. When the relevant trap bit is 0, exc_status holds and no request is made.
- R8: When faults coincide, the priority is enabled bus error, then stack violation, then misalignment. Only the winner is recorded.
- R9: Results appear at the clock edge that samples the access. exc_req is high for exactly one cycle per raising fault. exc_addr and exc_status hold on every cycle without a recorded fault.
- R10: With acc_valid low, acc_addr, acc_size and acc_stack are not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A data access is present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_size | input | 2 | 00 byte, 01 halfword, 1x word |
| acc_write | input | 1 | 1 for a store |
| acc_rd | input | REG_W | Destination/source register number |
| acc_stack | input | 1 | Access goes through the stack pointer |
| stk_lo | input | ADDR_W | Lowest legal stack address |
| stk_hi | input | ADDR_W | Highest legal stack address |
| bus_err | input | 1 | Unassigned-address bus error this cycle |
| bus_ifetch | input | 1 | Bus error came from instruction fetch |
| bus_addr | input | ADDR_W | Address of the bus error |
| exc_enable | input | 1 | Global exception enable |
| itrap_en | input | 1 | Instruction-bus errors trap |
| dtrap_en | input | 1 | Data-bus errors trap |
| exc_addr | output | ADDR_W | Exception address register |
| exc_status | output | STAT_W | Exception status word |
| exc_req | output | 1 | One-cycle exception request |

## Verification
If the state machine were left in `ST_TRAP` by mistake, exc_req would remain high on the cycle after a raising fault. The bench checks for this one cycle after each trap. A wrong priority or a wrong field packing appears in exc_status at the very edge that samples the fault, so every scenario reads the status one cycle after the stimulus. A hold-enable that leaks would overwrite exc_addr on a clean or ignored access. The bench therefore checks the saved value after such stimuli.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int CAUSE_W = 5;

    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_IBUS     = 5'd3;
    localparam logic [CAUSE_W-1:0] CAUSE_DBUS     = 5'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_STACK    = 5'd7;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_TRAP  = 1'b1
    } trap_state_e;

endpackage

// File: rtl/afc_classify.sv
module afc_classify
    import afc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STAT_W = 32,
    parameter int REG_W  = 5
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  acc_size_e         acc_size,
    input  logic              acc_write,
    input  logic [REG_W-1:0]  acc_rd,
    input  logic              acc_stack,
    input  logic [ADDR_W-1:0] stk_lo,
    input  logic [ADDR_W-1:0] stk_hi,
    input  logic              bus_err,
    input  logic              bus_ifetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              exc_enable,
    input  logic              itrap_en,
    input  logic              dtrap_en,
    output logic              load_addr,
    output logic              load_stat,
    output logic              raise,
    output logic [ADDR_W-1:0] new_addr,
    output logic [STAT_W-1:0] new_stat
);

    localparam int RD_LSB  = CAUSE_W;
    localparam int WR_BIT  = RD_LSB + REG_W;
    localparam int WD_BIT  = WR_BIT + 1;

    logic [1:0] size_mask;
    logic       is_word;
    logic       bus_live;
    logic       stk_bad;
    logic       misal;
    logic       side_trap;

    always_comb begin
        unique case (acc_size)
            SZ_BYTE: size_mask = 2'b00;
            SZ_HALF: size_mask = 2'b01;
            SZ_WORD,
            SZ_WIDE: size_mask = 2'b11;
        endcase
    end

    assign is_word   = acc_size[1];
    assign bus_live  = bus_err && exc_enable;
    assign stk_bad   = acc_valid && acc_stack && ((acc_addr < stk_lo) || (acc_addr > stk_hi));
    assign misal     = acc_valid && ((acc_addr[1:0] & size_mask) != 2'b00);
    assign side_trap = bus_ifetch ? itrap_en : dtrap_en;

    always_comb begin
        load_addr = 1'b0;
        load_stat = 1'b0;
        raise     = 1'b0;
        new_addr  = acc_addr;
        new_stat  = '0;
        if (bus_live) begin
            load_addr     = 1'b1;
            load_stat     = side_trap;
            raise         = side_trap;
            new_addr      = bus_addr;
            new_stat[CAUSE_W-1:0] = bus_ifetch ? CAUSE_IBUS : CAUSE_DBUS;
        end else if (stk_bad) begin
            load_addr     = 1'b1;
            load_stat     = 1'b1;
            raise         = 1'b1;
            new_stat[CAUSE_W-1:0] = CAUSE_STACK;
        end else if (misal) begin
            load_addr     = 1'b1;
            load_stat     = 1'b1;
            raise         = exc_enable;
            new_stat[CAUSE_W-1:0]      = CAUSE_MISALIGN;
            new_stat[WR_BIT-1:RD_LSB]  = acc_rd;
            new_stat[WR_BIT]           = acc_write;
            new_stat[WD_BIT]           = is_word;
        end
    end

    always_comb begin
        assert (!(raise && !load_addr)) else $error("AST_RAISE_WITHOUT_RECORD"); // R9
        assert (!(load_stat && !load_addr)) else $error("AST_STAT_WITHOUT_ADDR"); // R7
    end

endmodule

// File: rtl/afc_capture.sv
module afc_capture
    import afc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic              load_stat,
    input  logic              raise,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [STAT_W-1:0] new_stat,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [STAT_W-1:0] exc_status,
    output logic              exc_req
);

    trap_state_e state_q;
    trap_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: state_d = raise ? ST_TRAP : ST_QUIET;
            ST_TRAP:  state_d = raise ? ST_TRAP : ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_addr   <= '0;
            exc_status <= '0;
        end else begin
            if (load_addr) exc_addr   <= new_addr;
            if (load_stat) exc_status <= new_stat;
        end
    end

    assign exc_req = (state_q == ST_TRAP);

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_addr |=> $stable(exc_addr)); // R9
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stat |=> $stable(exc_status)); // R9
    AST_REQ_FOLLOWS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> exc_req); // R9
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !raise |=> !exc_req); // R9

endmodule

// File: rtl/access_fault_chk.sv
module access_fault_chk
    import afc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STAT_W = 32,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    input  logic [REG_W-1:0]  acc_rd,
    input  logic              acc_stack,
    input  logic [ADDR_W-1:0] stk_lo,
    input  logic [ADDR_W-1:0] stk_hi,
    input  logic              bus_err,
    input  logic              bus_ifetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              exc_enable,
    input  logic              itrap_en,
    input  logic              dtrap_en,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [STAT_W-1:0] exc_status,
    output logic              exc_req
);

    localparam int MIN_STAT_W = CAUSE_W + REG_W + 2;

    logic              load_addr;
    logic              load_stat;
    logic              raise;
    logic [ADDR_W-1:0] new_addr;
    logic [STAT_W-1:0] new_stat;

    initial begin
        assert (STAT_W >= MIN_STAT_W) else $error("status word too narrow");
    end

    afc_classify #(
        .ADDR_W (ADDR_W),
        .STAT_W (STAT_W),
        .REG_W  (REG_W)
    ) u_classify (
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .acc_size   (acc_size_e'(acc_size)),
        .acc_write  (acc_write),
        .acc_rd     (acc_rd),
        .acc_stack  (acc_stack),
        .stk_lo     (stk_lo),
        .stk_hi     (stk_hi),
        .bus_err    (bus_err),
        .bus_ifetch (bus_ifetch),
        .bus_addr   (bus_addr),
        .exc_enable (exc_enable),
        .itrap_en   (itrap_en),
        .dtrap_en   (dtrap_en),
        .load_addr  (load_addr),
        .load_stat  (load_stat),
        .raise      (raise),
        .new_addr   (new_addr),
        .new_stat   (new_stat)
    );

    afc_capture #(
        .ADDR_W (ADDR_W),
        .STAT_W (STAT_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_addr  (load_addr),
        .load_stat  (load_stat),
        .raise      (raise),
        .new_addr   (new_addr),
        .new_stat   (new_stat),
        .exc_addr   (exc_addr),
        .exc_status (exc_status),
        .exc_req    (exc_req)
    );

    AST_STACK_ALWAYS_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_stack && !(bus_err && exc_enable)
         && ((acc_addr < stk_lo) || (acc_addr > stk_hi))) |=> exc_req); // R5
    AST_BUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !exc_enable && !acc_valid) |=> (!exc_req && $stable(exc_addr))); // R6
    AST_BYTE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_size == 2'b00 && !acc_stack && !bus_err) |=> (!exc_req && $stable(exc_addr))); // R2
    AST_MISALIGN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !exc_enable && !acc_stack && !bus_err) |=> !exc_req); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !bus_err) |=> (!exc_req && $stable(exc_addr) && $stable(exc_status))); // R10

endmodule

// File: tb/test_access_fault_chk.sv
`timescale 1ns/1ps
module test_access_fault_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid, acc_write, acc_stack;
    logic [31:0] acc_addr, stk_lo, stk_hi, bus_addr;
    logic [1:0]  acc_size;
    logic [4:0]  acc_rd;
    logic        bus_err, bus_ifetch, exc_enable, itrap_en, dtrap_en;
    logic [31:0] exc_addr, exc_status;
    logic        exc_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    access_fault_chk i_access_fault_chk (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_write(acc_write), .acc_rd(acc_rd),
        .acc_stack(acc_stack), .stk_lo(stk_lo), .stk_hi(stk_hi),
        .bus_err(bus_err), .bus_ifetch(bus_ifetch), .bus_addr(bus_addr),
        .exc_enable(exc_enable), .itrap_en(itrap_en), .dtrap_en(dtrap_en),
        .exc_addr(exc_addr), .exc_status(exc_status), .exc_req(exc_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        acc_valid = 0; acc_addr = 0; acc_size = 0; acc_write = 0; acc_rd = 0;
        acc_stack = 0; bus_err = 0; bus_ifetch = 0; bus_addr = 0;
    endtask

    // drive one cycle of stimulus, then wait to the negedge after the sampling edge
    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [31:0] mis_stat(input logic [4:0] rd, input logic wr, input logic word);
        return 32'd1 | (32'(rd) << 5) | (32'(wr) << 10) | (32'(word) << 11);
    endfunction

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                          input logic [4:0] rd, input logic stk);
        acc_valid = 1; acc_addr = a; acc_size = sz; acc_write = wr; acc_rd = rd; acc_stack = stk;
        step();
        idle_inputs();
    endtask

    task automatic t_reset();
        chk("R1 exc_addr", exc_addr, 32'h0);
        chk("R1 exc_status", exc_status, 32'h0);
        chk("R1 exc_req", {31'b0, exc_req}, 32'h0);
    endtask

    task automatic t_misalign_half();
        exc_enable = 1;
        access(32'h0000_1001, 2'b01, 1'b1, 5'd17, 1'b0);
        chk("R2 half misaligned req", {31'b0, exc_req}, 32'h1);
        chk("R3 half addr", exc_addr, 32'h0000_1001);
        chk("R3 half status", exc_status, mis_stat(5'd17, 1'b1, 1'b0));
        step();
        chk("R9 req one cycle", {31'b0, exc_req}, 32'h0);
        chk("R9 addr hold", exc_addr, 32'h0000_1001);
    endtask

    task automatic t_misalign_word();
        exc_enable = 1;
        access(32'h0000_2002, 2'b10, 1'b0, 5'd31, 1'b0);
        chk("R3 word addr", exc_addr, 32'h0000_2002);
        chk("R3 word status", exc_status, mis_stat(5'd31, 1'b0, 1'b1));
        chk("R2 word req", {31'b0, exc_req}, 32'h1);
        access(32'h0000_3003, 2'b11, 1'b1, 5'd2, 1'b0);
        chk("R2 size 11 as word", exc_status, mis_stat(5'd2, 1'b1, 1'b1));
    endtask

    task automatic t_aligned();
        exc_enable = 1;
        access(32'h0000_4003, 2'b00, 1'b0, 5'd1, 1'b0);
        chk("R2 byte never misaligned req", {31'b0, exc_req}, 32'h0);
        chk("R2 byte addr hold", exc_addr, 32'h0000_3003);
        access(32'h0000_4002, 2'b01, 1'b0, 5'd1, 1'b0);
        chk("R2 aligned half req", {31'b0, exc_req}, 32'h0);
        access(32'h0000_4004, 2'b10, 1'b0, 5'd1, 1'b0);
        chk("R2 aligned word addr hold", exc_addr, 32'h0000_3003);
    endtask

    task automatic t_misalign_disabled();
        exc_enable = 0;
        access(32'h0000_5001, 2'b10, 1'b0, 5'd9, 1'b0);
        chk("R4 no req when disabled", {31'b0, exc_req}, 32'h0);
        chk("R4 addr still recorded", exc_addr, 32'h0000_5001);
        chk("R4 status still recorded", exc_status, mis_stat(5'd9, 1'b0, 1'b1));
        exc_enable = 1;
    endtask

    task automatic t_stack();
        stk_lo = 32'h0000_8000; stk_hi = 32'h0000_8FFC;
        exc_enable = 0;
        access(32'h0000_7FFC, 2'b10, 1'b0, 5'd1, 1'b1);
        chk("R5 below low req", {31'b0, exc_req}, 32'h1);
        chk("R5 below low status", exc_status, 32'd7);
        chk("R5 below low addr", exc_addr, 32'h0000_7FFC);
        access(32'h0000_9000, 2'b10, 1'b0, 5'd1, 1'b1);
        chk("R5 above high addr", exc_addr, 32'h0000_9000);
        access(32'h0000_8000, 2'b10, 1'b0, 5'd1, 1'b1);
        chk("R5 low bound legal", {31'b0, exc_req}, 32'h0);
        access(32'h0000_8FFC, 2'b10, 1'b0, 5'd1, 1'b1);
        chk("R5 high bound legal req", {31'b0, exc_req}, 32'h0);
        chk("R5 high bound legal addr", exc_addr, 32'h0000_9000);
        exc_enable = 1;
    endtask

    task automatic t_bus_masked();
        exc_enable = 0; itrap_en = 1; dtrap_en = 1;
        bus_err = 1; bus_ifetch = 1; bus_addr = 32'hBAD0_0000;
        step();
        idle_inputs();
        chk("R6 masked bus req", {31'b0, exc_req}, 32'h0);
        chk("R6 masked bus addr", exc_addr, 32'h0000_9000);
        chk("R6 masked bus status", exc_status, 32'd7);
        exc_enable = 1;
    endtask

    task automatic t_bus_enabled();
        exc_enable = 1; itrap_en = 1; dtrap_en = 0;
        bus_err = 1; bus_ifetch = 1; bus_addr = 32'hC000_0010;
        step(); idle_inputs();
        chk("R7 ibus req", {31'b0, exc_req}, 32'h1);
        chk("R7 ibus status", exc_status, 32'd3);
        chk("R7 ibus addr", exc_addr, 32'hC000_0010);
        bus_err = 1; bus_ifetch = 0; bus_addr = 32'hD000_0020;
        step(); idle_inputs();
        chk("R7 dbus cfg off req", {31'b0, exc_req}, 32'h0);
        chk("R7 dbus cfg off addr", exc_addr, 32'hD000_0020);
        chk("R7 dbus cfg off status held", exc_status, 32'd3);
        dtrap_en = 1;
        bus_err = 1; bus_ifetch = 0; bus_addr = 32'hD000_0030;
        step(); idle_inputs();
        chk("R7 dbus req", {31'b0, exc_req}, 32'h1);
        chk("R7 dbus status", exc_status, 32'd4);
    endtask

    task automatic t_priority();
        exc_enable = 1; itrap_en = 1; dtrap_en = 1;
        stk_lo = 32'h0000_8000; stk_hi = 32'h0000_8FFC;
        acc_valid = 1; acc_addr = 32'h0000_0101; acc_size = 2'b10; acc_stack = 1; acc_rd = 5'd4;
        bus_err = 1; bus_ifetch = 0; bus_addr = 32'hE000_0000;
        step(); idle_inputs();
        chk("R8 bus wins status", exc_status, 32'd4);
        chk("R8 bus wins addr", exc_addr, 32'hE000_0000);
        acc_valid = 1; acc_addr = 32'h0000_0101; acc_size = 2'b10; acc_stack = 1; acc_rd = 5'd4;
        step(); idle_inputs();
        chk("R8 stack beats misalign", exc_status, 32'd7);
        exc_enable = 0;
        acc_valid = 1; acc_addr = 32'h0000_0203; acc_size = 2'b01; acc_rd = 5'd6;
        bus_err = 1; bus_ifetch = 1; bus_addr = 32'hF000_0000;
        step(); idle_inputs();
        chk("R6 masked bus lets misalign through", exc_status, mis_stat(5'd6, 1'b0, 1'b0));
        chk("R6 masked bus addr not taken", exc_addr, 32'h0000_0203);
        exc_enable = 1;
    endtask

    task automatic t_invalid();
        exc_enable = 1;
        acc_valid = 0; acc_addr = 32'h0000_0007; acc_size = 2'b10; acc_stack = 1;
        step(); idle_inputs();
        chk("R10 invalid ignored req", {31'b0, exc_req}, 32'h0);
        chk("R10 invalid ignored addr", exc_addr, 32'h0000_0203);
    endtask

    task automatic t_back_to_back();
        exc_enable = 1;
        access(32'h0000_0011, 2'b01, 1'b0, 5'd3, 1'b0);
        chk("R9 first of pair req", {31'b0, exc_req}, 32'h1);
        access(32'h0000_0021, 2'b01, 1'b0, 5'd3, 1'b0);
        chk("R9 second of pair req", {31'b0, exc_req}, 32'h1);
        chk("R9 second of pair addr", exc_addr, 32'h0000_0021);
        step();
        chk("R9 pair release", {31'b0, exc_req}, 32'h0);
    endtask

    initial begin
        idle_inputs();
        stk_lo = 0; stk_hi = 32'hFFFF_FFFF;
        exc_enable = 0; itrap_en = 0; dtrap_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_misalign_half();
        t_misalign_word();
        t_aligned();
        t_misalign_disabled();
        t_stack();
        t_bus_masked();
        t_bus_enabled();
        t_priority();
        t_invalid();
        t_back_to_back();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule